// File: doc/BRIEF.md
# Configurable GPIO Port Bank

A bank of general-purpose pins controlled through a small register interface with separate read and write strobes. Every pin owns a configuration register that sets its direction, whether its logic value is inverted, and whether it feeds either of two shared group interrupt lines. All pins share one data register at address 0. The configuration register of pin `i` sits at address `i + 1`.

Whether a host access reaches the pin or the data register depends on the pin's direction. On an input pin, a read takes a snapshot of the synchronized pin level, adjusted for polarity, and a write is discarded. On an output pin, a write updates the stored bit, which is driven onto the pin after polarity adjustment, and a read returns the stored bit. Pin levels pass through a two-flop synchronizer before a read or an interrupt uses them.

Top module: `pio_bank`

## Requirements
- R1: In a pin's configuration register, bit 0 = 1 selects input (0 = output) and bit 1 = 1 selects inverted polarity. Bit 2 enables the pin onto group interrupt 1 and bit 5 enables it onto group interrupt 2. A read of the register returns these four bits with every other bit zero.
- R2: After reset, every configuration register reads 0x01 (input, not inverted, no interrupt enables), the data register is 0, no pin is driven, both group interrupts are low and `hst_rdata` is 0.
- R3: A read strobe at address 0 loads `hst_rdata`, one clock later, with the synchronized level of each input pin XOR its polarity bit. That value holds until the next read strobe.
- R4: A write to address 0 leaves the stored data bit of every input pin unchanged.
- R5: A write to address 0 stores the bit of each output pin, and the pin then drives the stored bit XOR its polarity bit.
- R6: A read at address 0 returns the stored data bit for each output pin, whatever level is present at that pin.
- R7: Group interrupt 1 (2) is the OR, over the input pins with bit 2 (bit 5) set, of the synchronized level XOR polarity. Output pins never contribute.
- R8: `pin_oe` is high for a pin exactly when that pin is configured as an output.
- R9: Changing a pin's direction keeps its stored data bit. A new configuration acts on the outputs from the clock edge that captures the write.
- R10: A change at `pin_in` reaches the group interrupts after the second rising clock edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | ADDR_W | Register address: 0 data, i+1 configuration of pin i |
| hst_wdata | input | DATA_W | Write data |
| hst_wr | input | 1 | Write strobe, one cycle |
| hst_rd | input | 1 | Read strobe, one cycle |
| hst_rdata | output | DATA_W | Read data, valid the cycle after the strobe and held |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Value driven onto each pin |
| pin_oe | output | NUM_PINS | Output enable for each pin |
| grp_irq1 | output | 1 | Group interrupt 1 |
| grp_irq2 | output | 1 | Group interrupt 2 |

## Verification
The bench writ all-ones to the data register while every pin is an input, then turns one pin into an output. A design that accepts writes on input pins would start driving a 1 there instead of 0. Reads are issued on a mix of input and output pins, with the output pins' pin levels set opposite to the stored bits. A design that returns the pin level for outputs, or that skips polarity on either path, gives the wrong byte. The bench changes a pin level after a read to confirm the latched value holds. It also checks the group interrupt one edge after an input change, where it must not have moved yet, to catch a missing synchronizer stage. Finally it checks that an enabled pin stops contributing once it becomes an output.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int CFG_DIR_BIT = 0;
    localparam int CFG_POL_BIT = 1;
    localparam int CFG_G1_BIT  = 2;
    localparam int CFG_G2_BIT  = 5;
    localparam int CFG_BYTE_W  = 8;

    typedef struct packed {
        logic grp2_en;
        logic grp1_en;
        logic invert;
        logic is_input;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{grp2_en: 1'b0, grp1_en: 1'b0,
                                       invert: 1'b0, is_input: 1'b1};

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CFG  = 2'd2
    } reg_sel_e;

    function automatic pin_cfg_t cfg_unpack(input logic [CFG_BYTE_W-1:0] b);
        pin_cfg_t c;
        c.is_input = b[CFG_DIR_BIT];
        c.invert   = b[CFG_POL_BIT];
        c.grp1_en  = b[CFG_G1_BIT];
        c.grp2_en  = b[CFG_G2_BIT];
        return c;
    endfunction

    function automatic logic [CFG_BYTE_W-1:0] cfg_pack(input pin_cfg_t c);
        logic [CFG_BYTE_W-1:0] b;
        b = '0;
        b[CFG_DIR_BIT] = c.is_input;
        b[CFG_POL_BIT] = c.invert;
        b[CFG_G1_BIT]  = c.grp1_en;
        b[CFG_G2_BIT]  = c.grp2_en;
        return b;
    endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/pio_pin.sv
module pio_pin
    import pio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_BYTE_W-1:0] cfg_wbyte,
    input  logic                  data_we,
    input  logic                  data_wbit,
    input  logic                  pin_lvl,
    output pin_cfg_t              cfg_q,
    output logic                  data_q,
    output logic                  rd_bit,
    output logic                  pin_out,
    output logic                  pin_oe,
    output logic                  g1_req,
    output logic                  g2_req
);
    logic lvl_adj;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (cfg_we) begin
            cfg_q <= cfg_unpack(cfg_wbyte);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= 1'b0;
        end else if (data_we && !cfg_q.is_input) begin
            data_q <= data_wbit;
        end
    end

    assign lvl_adj = pin_lvl ^ cfg_q.invert;
    assign rd_bit  = cfg_q.is_input ? lvl_adj : data_q;
    assign pin_out = data_q ^ cfg_q.invert;
    assign pin_oe  = ~cfg_q.is_input;
    assign g1_req  = cfg_q.is_input & cfg_q.grp1_en & lvl_adj;
    assign g2_req  = cfg_q.is_input & cfg_q.grp2_en & lvl_adj;
endmodule

// File: rtl/pio_host_if.sv
module pio_host_if
    import pio_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic                                wr,
    input  logic                                rd,
    input  logic [NUM_PINS-1:0]                 rd_bits,
    input  logic [NUM_PINS-1:0][CFG_BYTE_W-1:0] cfg_bytes,
    output logic [NUM_PINS-1:0]                 cfg_we,
    output logic                                data_we,
    output logic [DATA_W-1:0]                   rdata
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_nxt;

    always_comb begin
        if (addr == '0) begin
            sel = SEL_DATA;
        end else if (int'(addr) <= NUM_PINS) begin
            sel = SEL_CFG;
        end else begin
            sel = SEL_NONE;
        end
    end

    assign data_we = wr && (sel == SEL_DATA);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_we
        assign cfg_we[i] = wr && (sel == SEL_CFG) && (int'(addr) == i + 1);
    end

    always_comb begin
        rd_nxt = '0;
        case (sel)
            SEL_DATA: rd_nxt[NUM_PINS-1:0] = rd_bits;
            SEL_CFG: begin
                for (int i = 0; i < NUM_PINS; i++) begin
                    if (int'(addr) == i + 1) begin
                        rd_nxt[CFG_BYTE_W-1:0] = cfg_bytes[i];
                    end
                end
            end
            default: rd_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= rd_nxt;
        end
    end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import pio_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = $clog2(NUM_PINS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   hst_addr,
    input  logic [DATA_W-1:0]   hst_wdata,
    input  logic                hst_wr,
    input  logic                hst_rd,
    output logic [DATA_W-1:0]   hst_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                grp_irq1,
    output logic                grp_irq2
);
    logic [NUM_PINS-1:0]                 pin_sync;
    logic [NUM_PINS-1:0]                 cfg_we;
    logic                                data_we;
    logic [NUM_PINS-1:0]                 rd_bits;
    logic [NUM_PINS-1:0][CFG_BYTE_W-1:0] cfg_bytes;
    logic [NUM_PINS-1:0]                 g1_vec;
    logic [NUM_PINS-1:0]                 g2_vec;
    logic [NUM_PINS-1:0]                 in_vec;
    logic [NUM_PINS-1:0]                 pol_vec;
    logic [NUM_PINS-1:0]                 g1en_vec;
    logic [NUM_PINS-1:0]                 data_vec;

    pio_sync #(.W(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .q_sync  (pin_sync)
    );

    pio_host_if #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_host (
        .clk       (clk),
        .rst       (rst),
        .addr      (hst_addr),
        .wr        (hst_wr),
        .rd        (hst_rd),
        .rd_bits   (rd_bits),
        .cfg_bytes (cfg_bytes),
        .cfg_we    (cfg_we),
        .data_we   (data_we),
        .rdata     (hst_rdata)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_cfg_t cfg_q;

        pio_pin u_pin (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (cfg_we[i]),
            .cfg_wbyte (hst_wdata[CFG_BYTE_W-1:0]),
            .data_we   (data_we),
            .data_wbit (hst_wdata[i]),
            .pin_lvl   (pin_sync[i]),
            .cfg_q     (cfg_q),
            .data_q    (data_vec[i]),
            .rd_bit    (rd_bits[i]),
            .pin_out   (pin_out[i]),
            .pin_oe    (pin_oe[i]),
            .g1_req    (g1_vec[i]),
            .g2_req    (g2_vec[i])
        );

        assign cfg_bytes[i] = cfg_pack(cfg_q);
        assign in_vec[i]    = cfg_q.is_input;
        assign pol_vec[i]   = cfg_q.invert;
        assign g1en_vec[i]  = cfg_q.grp1_en;
    end

    assign grp_irq1 = |g1_vec;
    assign grp_irq2 = |g2_vec;
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
    parameter int NUM_PINS = 8,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   hst_addr,
    input logic [DATA_W-1:0]   hst_wdata,
    input logic                hst_wr,
    input logic                hst_rd,
    input logic [DATA_W-1:0]   hst_rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                grp_irq1,
    input logic [NUM_PINS-1:0] in_vec,
    input logic [NUM_PINS-1:0] pol_vec,
    input logic [NUM_PINS-1:0] g1en_vec,
    input logic [NUM_PINS-1:0] data_vec
);
    assert_reset_quiet_R2: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && hst_rdata == '0 && !grp_irq1));

    assert_in_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (hst_wr && hst_addr == '0) |=> ((pin_out & ~pin_oe) == ($past(pin_out) & ~$past(pin_oe))));

    assert_out_drive_R5: assert property (@(posedge clk) disable iff (rst)
        (hst_wr && hst_addr == '0) |=>
            ((pin_out & pin_oe) == (($past(hst_wdata[NUM_PINS-1:0]) ^ pol_vec) & pin_oe)));

    assert_out_read_R6: assert property (@(posedge clk) disable iff (rst)
        (hst_rd && hst_addr == '0) |=>
            ((hst_rdata[NUM_PINS-1:0] & ~$past(in_vec)) == ($past(data_vec) & ~$past(in_vec))));

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
        grp_irq1 |-> ((g1en_vec & in_vec) != '0));

    assert_oe_dir_R8: assert property (@(posedge clk) disable iff (rst)
        (hst_wr && hst_addr == ADDR_W'(1) && !hst_wdata[0]) |=> pin_oe[0]);
endmodule

bind pio_bank pio_bank_chk #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hst_addr  (hst_addr),
    .hst_wdata (hst_wdata),
    .hst_wr    (hst_wr),
    .hst_rd    (hst_rd),
    .hst_rdata (hst_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .grp_irq1  (grp_irq1),
    .in_vec    (in_vec),
    .pol_vec   (pol_vec),
    .g1en_vec  (g1en_vec),
    .data_vec  (data_vec)
);

// File: tb/sim_pio_bank.sv
module sim_pio_bank;
    localparam int NP = 8;
    localparam int DW = 8;
    localparam int AW = $clog2(NP + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] hst_addr = '0;
    logic [DW-1:0] hst_wdata = '0;
    logic          hst_wr = 1'b0;
    logic          hst_rd = 1'b0;
    logic [DW-1:0] hst_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          grp_irq1;
    logic          grp_irq2;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    pio_bank #(.NUM_PINS(NP), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_rdata(hst_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .grp_irq1(grp_irq1), .grp_irq2(grp_irq2)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; hst_wr = 1'b0; hst_rd = 1'b0; pin_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_reg(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        hst_addr = AW'(a); hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [DW-1:0] d);
        @(negedge clk);
        hst_addr = AW'(a); hst_rd = 1'b1;
        @(negedge clk);
        hst_rd = 1'b0;
        d = hst_rdata;
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        do_reset();
        check("R2 oe", 32'(pin_oe), 0);
        check("R2 irq", {grp_irq2, grp_irq1}, 0);
        check("R2 rdata", 32'(hst_rdata), 0);
        rd_reg(1, d);
        check("R2 cfg reset", 32'(d), 32'h01);
        rd_reg(0, d);
        check("R2 data", 32'(d), 0);
    endtask

    task automatic t_cfg_fields();
        logic [DW-1:0] d;
        do_reset();
        wr_reg(7, 8'hFF);
        rd_reg(7, d);
        check("R1 cfg readback", 32'(d), 32'h27);
        check("R1 bit0=1 input", 32'(pin_oe[6]), 0);
    endtask

    task automatic t_input_read();
        logic [DW-1:0] d;
        do_reset();
        set_pins(8'hA5);
        rd_reg(0, d);
        check("R3 plain read", 32'(d), 32'hA5);
        wr_reg(1, 8'h03);
        wr_reg(2, 8'h03);
        rd_reg(0, d);
        check("R3 inverted read", 32'(d), 32'hA6);
        set_pins(8'h00);
        check("R3 latch held", 32'(hst_rdata), 32'hA6);
        rd_reg(0, d);
        check("R3 new read", 32'(d), 32'h03);
    endtask

    task automatic t_write_ignored();
        do_reset();
        wr_reg(0, 8'hFF);
        wr_reg(4, 8'h00);
        check("R4 ignored write", 32'(pin_out[3]), 0);
        check("R8 oe output", 32'(pin_oe), 32'h08);
    endtask

    task automatic t_output();
        logic [DW-1:0] d;
        do_reset();
        wr_reg(1, 8'h03); wr_reg(2, 8'h03); wr_reg(4, 8'h00);
        wr_reg(5, 8'h00); wr_reg(6, 8'h02); wr_reg(7, 8'h00); wr_reg(8, 8'h00);
        wr_reg(0, 8'h30);
        check("R5 pin_out", 32'(pin_out & pin_oe), 32'h10);
        check("R8 oe map", 32'(pin_oe), 32'hF8);
        set_pins(8'h0F);
        rd_reg(0, d);
        check("R6 output read", 32'(d), 32'h34);
    endtask

    task automatic t_dir_change();
        do_reset();
        wr_reg(3, 8'h00);
        wr_reg(0, 8'h04);
        check("R5 drive", 32'(pin_out[2]), 1);
        wr_reg(3, 8'h01);
        check("R9 now input", 32'(pin_oe[2]), 0);
        wr_reg(3, 8'h00);
        check("R9 data kept", 32'(pin_out[2] & pin_oe[2]), 1);
    endtask

    task automatic t_irq();
        do_reset();
        wr_reg(1, 8'h05); wr_reg(2, 8'h21); wr_reg(3, 8'h07);
        check("R7 inverted low pin", {grp_irq2, grp_irq1}, 32'h1);
        @(negedge clk);
        pin_in = 8'h04;
        @(negedge clk);
        check("R10 one edge", 32'(grp_irq1), 1);
        @(negedge clk);
        check("R10 two edges", 32'(grp_irq1), 0);
        set_pins(8'h0E);
        check("R7 grp2 and unenabled", {grp_irq2, grp_irq1}, 32'h2);
        wr_reg(2, 8'h20);
        check("R7 output excluded", 32'(grp_irq2), 0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_cfg_fields();
        t_input_read();
        t_write_ignored();
        t_output();
        t_dir_change();
        t_irq();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule